// File: doc/BRIEF.md
# Deglitched Power-Good Monitor

This block turns a set of comparator and protection flags from a step-down regulator into a power-good indication for an open-drain pin. The flags are: feedback above the upper threshold (92.5 % of the reference), feedback below the lower threshold (90 % of the reference), reference above its minimum level (0.54 V), converter shutdown, supply undervoltage lockout and thermal shutdown. They are evaluated once per oscillator cycle, which a single-cycle tick input marks.

The indication goes good only after the good condition has held for a qualification window of consecutive ticks. It goes bad only after the bad condition has held for its own window of the same length. The two thresholds give hysteresis. Between them the current state is kept and both qualification counts restart. Shutdown, lockout and thermal shutdown pull the pin low at once, with no deglitch. The pad driver uses the pull-down enable: a good state releases the line and never drives it high.

Top module: `pgood_monitor`

## Requirements
- R1: After reset the indication is not good: `pgood_o` is 0 and `pd_en_o` is 1.
- R2: While not good, the indication becomes good after the QUAL_TICKS-th consecutive tick (default 48) on which `fb_above_i` is 1, `fb_below_i` is 0 and `ref_ok_i` is 1, and not after fewer. `pgood_o` rises in the cycle after that tick's clock edge.
- R3: Any tick that breaks a qualification run restarts that run from zero.
- R4: While good, the indication becomes not good after QUAL_TICKS consecutive ticks on which `fb_below_i` is 1 or `ref_ok_i` is 0.
- R5: `ref_ok_i` low with feedback above the upper threshold still counts as a bad condition.
- R6: A tick with feedback between the thresholds (both feedback flags 0, `ref_ok_i` 1) keeps the current state and restarts both runs.
- R7: Any of `shdn_i`, `uvlo_i`, `tsd_i` at 1 forces `pgood_o` to 0 in the same cycle, clears the state and restarts the good-condition run.
- R8: In cycles with `tick_i` at 0 the feedback and reference flags have no effect and no run advances.
- R9: `pd_en_o` is always the inverse of `pgood_o`.
- R10: With both feedback flags at 1 on a tick, the tick counts as a bad condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe, once per oscillator cycle |
| fb_above_i | input | 1 | Feedback above upper (92.5 %) threshold |
| fb_below_i | input | 1 | Feedback below lower (90 %) threshold |
| ref_ok_i | input | 1 | Reference above minimum level |
| shdn_i | input | 1 | Converter in shutdown |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| tsd_i | input | 1 | Thermal shutdown active |
| pgood_o | output | 1 | Power-good state, 1 = good |
| pd_en_o | output | 1 | Open-drain pull-down enable |

## Verification
The assertions assume that the comparator flags are synchronous and settled at each clock edge. They also assume that a state change can come only from a tick in the matching zone or from an override. They do not assume that the two feedback flags are mutually exclusive, so the conflicting case is in the checked space. The stimulus changes inputs only on the falling clock edge and holds them through the following rising edge. It drives both exclusive and conflicting flag patterns, and between ticks it drives deliberately misleading flag values to show that they are ignored.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  typedef enum logic [1:0] {
    ZONE_BAND = 2'd0,
    ZONE_HIGH = 2'd1,
    ZONE_LOW  = 2'd2
  } pg_zone_e;

  localparam int unsigned QUAL_DEF = 48;
  localparam int unsigned RUN_RISE = 0;
  localparam int unsigned RUN_FALL = 1;
  localparam int unsigned N_RUNS   = 2;
endpackage

// File: rtl/pgood_zone.sv
module pgood_zone
  import pgood_pkg::*;
(
  input  logic     fb_above_i,
  input  logic     fb_below_i,
  input  logic     ref_ok_i,
  output pg_zone_e zone_o
);
  // bad condition wins over good so conflicting flags fail safe
  always_comb begin
    if (fb_below_i || !ref_ok_i) zone_o = ZONE_LOW;
    else if (fb_above_i)         zone_o = ZONE_HIGH;
    else                         zone_o = ZONE_BAND;
  end
endmodule

// File: rtl/pgood_qual.sv
module pgood_qual #(
  parameter int unsigned LIMIT = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic hit_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = arm_i && tick_i && hit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (!hit_i || done_o)      cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && tick_i && !hit_i |=> cnt_q == '0);

  cnt_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R8
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && !tick_i |=> $stable(cnt_q) || !$past(arm_i));
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pgood_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = QUAL_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fb_above_i,
  input  logic fb_below_i,
  input  logic ref_ok_i,
  input  logic shdn_i,
  input  logic uvlo_i,
  input  logic tsd_i,
  output logic pgood_o,
  output logic pd_en_o
);
  pg_zone_e          zone;
  logic              force_low;
  logic              pg_q;
  logic [N_RUNS-1:0] arm, hit, done;

  assign force_low = shdn_i | uvlo_i | tsd_i;

  pgood_zone u_zone (
    .fb_above_i (fb_above_i),
    .fb_below_i (fb_below_i),
    .ref_ok_i   (ref_ok_i),
    .zone_o     (zone)
  );

  assign arm[RUN_RISE] = !pg_q && !force_low;
  assign hit[RUN_RISE] = (zone == ZONE_HIGH);
  assign arm[RUN_FALL] = pg_q && !force_low;
  assign hit[RUN_FALL] = (zone == ZONE_LOW);

  for (genvar g = 0; g < N_RUNS; g++) begin : g_run
    pgood_qual #(.LIMIT(QUAL_TICKS)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm[g]),
      .tick_i (tick_i),
      .hit_i  (hit[g]),
      .done_o (done[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pg_q <= 1'b0;
    else if (force_low)       pg_q <= 1'b0;
    else if (done[RUN_RISE])  pg_q <= 1'b1;
    else if (done[RUN_FALL])  pg_q <= 1'b0;
  end

  // overrides bypass the deglitch combinationally
  assign pgood_o = pg_q & ~force_low;
  assign pd_en_o = ~pgood_o;

  // R7
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low |=> !pg_q);

  // R2
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_q) |-> $past(tick_i && zone == ZONE_HIGH && !force_low));

  // R4
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pg_q) && !$past(force_low) |-> $past(tick_i && zone == ZONE_LOW));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !force_low |=> $stable(pg_q));

  // R6
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zone == ZONE_BAND && !force_low |=> $stable(pg_q));
endmodule

// File: tb/pgood_monitor_test.sv
module pgood_monitor_test;
  localparam int unsigned Q = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hi = 1'b0, lo = 1'b1, rf = 1'b0, sd = 1'b0, uv = 1'b0, ts = 1'b0;
  logic pgood, pd_en;

  always #4 clk = ~clk;

  pgood_monitor #(.QUAL_TICKS(Q)) uut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
    .fb_above_i (hi), .fb_below_i (lo), .ref_ok_i (rf),
    .shdn_i (sd), .uvlo_i (uv), .tsd_i (ts),
    .pgood_o (pgood), .pd_en_o (pd_en)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit m_pg = 0;
  int m_rise = 0, m_fall = 0;
  bit done = 0;

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated for the edge following the drive
  task automatic model(input bit t, input bit h, input bit l, input bit r, input bit ovr);
    bit good_c, bad_c;
    good_c = h && !l && r;
    bad_c  = l || !r;
    if (ovr) begin m_pg = 0; m_rise = 0; m_fall = 0; end
    else if (t) begin
      if (!m_pg) begin
        m_fall = 0;
        if (good_c) begin
          if (m_rise == Q - 1) begin m_pg = 1; m_rise = 0; end else m_rise++;
        end else m_rise = 0;
      end else begin
        m_rise = 0;
        if (bad_c) begin
          if (m_fall == Q - 1) begin m_pg = 0; m_fall = 0; end else m_fall++;
        end else m_fall = 0;
      end
    end else if (!m_pg) m_fall = 0; else m_rise = 0;
  endtask

  task automatic step(input bit t, input bit h, input bit l, input bit r,
                      input bit s, input bit u, input bit th, input string tag);
    item_t it;
    @(negedge clk);
    tick = t; hi = h; lo = l; rf = r; sd = s; uv = u; ts = th;
    model(t, h, l, r, s | u | th);
    it.exp = m_pg; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // tick with garbage between: idle cycles drive the opposite flags
  task automatic run(input int n, input bit h, input bit l, input bit r, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, h, l, r, 1'b0, 1'b0, 1'b0, tag);
      step(1'b0, !h, !l, !r, 1'b0, 1'b0, 1'b0, "R8");
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(pgood, it.exp, it.tag);
      check(pd_en, !pgood, "R9");
    end
  end

  initial begin
    fork
      begin
        #20;
        check(pgood, 1'b0, "R1");
        check(pd_en, 1'b1, "R1");
        @(negedge clk); rst_n = 1'b1;

        run(Q - 1, 1, 0, 1, "R2");
        run(1, 1, 0, 1, "R2");
        run(Q + 2, 0, 0, 1, "R6");
        run(Q - 1, 0, 1, 1, "R4");
        run(1, 0, 0, 1, "R6");
        run(Q - 1, 0, 1, 1, "R6");
        run(1, 0, 1, 1, "R4");

        run(30, 1, 0, 1, "R3");
        run(1, 0, 0, 1, "R3");
        run(Q - 1, 1, 0, 1, "R3");
        run(1, 1, 0, 1, "R3");

        run(Q, 1, 0, 0, "R5");

        run(20, 1, 0, 1, "R7");
        step(1'b1, 1, 0, 1, 1'b0, 1'b0, 1'b1, "R7");
        run(Q - 1, 1, 0, 1, "R7");
        run(1, 1, 0, 1, "R7");

        // same-cycle override while good
        @(negedge clk);
        sd = 1'b1; tick = 1'b0;
        #1 check(pgood, 1'b0, "R7");
        check(pd_en, 1'b1, "R7");
        model(1'b0, hi, lo, rf, 1'b1);
        step(1'b0, 1, 0, 1, 1'b0, 1'b1, 1'b0, "R7");
        run(Q, 1, 0, 1, "R7");

        run(Q - 1, 1, 1, 1, "R10");
        run(1, 1, 1, 1, "R10");
        run(Q, 1, 1, 1, "R10");

        wait (sb_q.size() == 0);
        @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule